// File: doc/BRIEF.md
# RTC SPI access sequencer

This block is the host-side master for a serial real-time clock that is reached over a four-wire SPI link. After reset it runs a start-up probe on its own. The probe checks that the clock answers with a plausible seconds value, restarts the oscillator if the clock reports that it stopped or that its supply dropped, and latches the clock's 12/24-hour setting. After that it serves read and set requests from the host. Each request is a 56-bit word of seven BCD bytes. Binary to BCD conversion is left to the host.

Every time access happens inside one chip-select window. The window opens with a fixed five-byte preamble: two single reads of control register 15, each followed by a dummy byte, and then the burst command for address 0. While the preamble is shifted out, the clock has time to finish any pending carry before the time bytes move. The seven time bytes then follow. Between any two windows, chip select stays low for a minimum time that is derived from the system clock frequency. The host sees a request/acknowledge handshake and a busy flag.

The controller is a single state machine with these states:
- S_BOOT: loads the first probe job, then moves to S_LAUNCH.
- S_IDLE: accepts a request and moves to S_LAUNCH.
- S_LAUNCH: raises chip select and starts one byte. It always moves to S_SHIFT.
- S_SHIFT: waits for the byte to finish. It moves back to S_LAUNCH for the next byte, or to S_GAP after the last byte.
- S_GAP: holds chip select low until the gap expires. It then moves to S_LAUNCH for a follow-up probe job, to S_IDLE (acknowledging a host request), or to S_ABSENT.
- S_ABSENT: the device was not found. This state is never left until the next reset.

Top module: `rtc_spi_seq`

## Requirements
- R1: While reset is active, spi_cs and spi_sclk are low and req_ack, probe_done and dev_absent are 0.
- R2: The link runs with spi_sclk idling low. spi_mosi changes with the rising edge of spi_sclk, bits go out MSB first, and spi_miso is sampled on the falling edge. Each spi_sclk phase, high and low, lasts sclk_div+1 system clock cycles.
- R3: The probe first sends a single-read command for the seconds register (0x0C) in a two-byte window. If bit 7 of the returned byte is set, dev_absent and probe_done go to 1. After that, chip select never rises again and no request is acknowledged.
- R4: The probe then reads control register 15 with command 0xFC. If bit 4 or bit 6 of the answer is set, a separate window sends 0xF8, 0x00, which clears that register. low_volt_warn takes the value of bit 6.
- R5: The probe then reads control register 14 with command 0xEC. mode_24h takes bit 5 of the answer and holds it from then on. probe_done then rises.
- R6: A read request (req_write=0) produces the 12 bytes FC,00,FC,00,04 followed by seven 0x00 bytes. Of the bytes received in positions 6 to 12, the first (seconds) goes to rd_time[55:48] and the last (year) to rd_time[7:0].
- R7: A set request (req_write=1) produces FC,00,FC,00,00 followed by the seven bytes of req_time, with req_time[55:48] sent first.
- R8: spi_cs stays high for the whole of a probe access or time access, including the gaps between its bytes.
- R9: Each time spi_cs falls, it stays low for at least GAP_CYC cycles, where GAP_CYC = ceil(CLK_HZ/1000 * CS_GAP_US / 1000).
- R10: req_ack is a one-cycle pulse, issued only after the inter-window gap has elapsed. busy falls in the same cycle. rd_time is valid while req_ack is high.
- R11: busy is high during the probe. A request held from reset release is started only after the probe has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_div | input | DIV_W | Half-period of spi_sclk, minus one, in clk cycles |
| req_valid | input | 1 | Request held until req_ack |
| req_write | input | 1 | 1: set time, 0: read time |
| req_time | input | 56 | BCD time to write, seconds in the top byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_time | output | 56 | BCD time read, seconds in the top byte |
| busy | output | 1 | Probe or access in progress |
| probe_done | output | 1 | Start-up probe finished |
| dev_absent | output | 1 | Probe found seconds bit 7 set |
| low_volt_warn | output | 1 | Low-voltage flag seen at start-up |
| mode_24h | output | 1 | Clock runs in 24-hour mode |
| spi_cs | output | 1 | Active-high chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the clock |
| spi_miso | input | 1 | Serial data from the clock |

## Verification
A register-level model of the clock in the bench answers the SPI traffic and records every byte of every chip-select window. The probe is exercised with four control-register patterns: both flags set, neither set, only the stop flag set, and an invalid seconds byte. Together these separate the clearing-write branch from the warning bit, and the absent path from the normal path. Time accesses use distinct digits in every byte, a write followed by a read-back, and two divider settings, so that byte order, command encoding, phase length and the chip-select gap are each distinguished. A request raised while the probe is still running shows whether requests wait for the probe to finish.

// File: rtl/rtcseq_pkg.sv
package rtcseq_pkg;

    localparam int TIME_BYTES = 7;
    localparam int TIME_W     = 8 * TIME_BYTES;
    localparam int PRE_BYTES  = 5;
    localparam int XFER_BYTES = PRE_BYTES + TIME_BYTES;
    localparam int IDX_W      = 4;

    localparam logic [3:0] REG_SEC  = 4'd0;
    localparam logic [3:0] REG_CTL1 = 4'd14;
    localparam logic [3:0] REG_CTL2 = 4'd15;

    localparam int BIT_SEC_BAD  = 7;
    localparam int BIT_OSC_STOP = 4;
    localparam int BIT_LOW_VOLT = 6;
    localparam int BIT_HOUR24   = 5;

    typedef enum logic [2:0] {
        S_BOOT,
        S_IDLE,
        S_LAUNCH,
        S_SHIFT,
        S_GAP,
        S_ABSENT
    } seq_state_t;

    typedef enum logic [2:0] {
        J_PROBE_SEC,
        J_READ_CTL2,
        J_CLEAR_CTL2,
        J_READ_CTL1,
        J_TIME_RD,
        J_TIME_WR,
        J_NONE
    } job_t;

    // Command byte: address in the upper nibble, bit 3 selects single
    // transfer, bit 2 selects read.
    function automatic logic [7:0] mk_cmd(input logic [3:0] addr,
                                          input logic single,
                                          input logic rd);
        return {addr, single, rd, 2'b00};
    endfunction

    function automatic logic [IDX_W-1:0] job_len(input job_t j);
        if (j == J_TIME_RD || j == J_TIME_WR)
            return IDX_W'(XFER_BYTES);
        return IDX_W'(2);
    endfunction

endpackage

// File: rtl/rtcseq_tx_select.sv
module rtcseq_tx_select
    import rtcseq_pkg::*;
(
    input  job_t                   job,
    input  logic [IDX_W-1:0]       idx,
    input  logic [TIME_W-1:0]      wr_time,
    output logic [7:0]             tx_byte
);

    logic [7:0] time_byte;

    always_comb begin
        time_byte = 8'h00;
        for (int k = 0; k < TIME_BYTES; k++) begin
            if (idx == IDX_W'(PRE_BYTES + k))
                time_byte = wr_time[8*(TIME_BYTES-1-k) +: 8];
        end
    end

    always_comb begin
        tx_byte = 8'h00;
        unique case (job)
            J_PROBE_SEC:  if (idx == '0) tx_byte = mk_cmd(REG_SEC,  1'b1, 1'b1);
            J_READ_CTL2:  if (idx == '0) tx_byte = mk_cmd(REG_CTL2, 1'b1, 1'b1);
            J_CLEAR_CTL2: if (idx == '0) tx_byte = mk_cmd(REG_CTL2, 1'b1, 1'b0);
            J_READ_CTL1:  if (idx == '0) tx_byte = mk_cmd(REG_CTL1, 1'b1, 1'b1);
            J_TIME_RD, J_TIME_WR: begin
                if (idx == IDX_W'(0) || idx == IDX_W'(2))
                    tx_byte = mk_cmd(REG_CTL2, 1'b1, 1'b1);
                else if (idx == IDX_W'(PRE_BYTES - 1))
                    tx_byte = mk_cmd(REG_SEC, 1'b0, job == J_TIME_RD);
                else if (idx >= IDX_W'(PRE_BYTES) && job == J_TIME_WR)
                    tx_byte = time_byte;
            end
            default: tx_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtcseq_byte_shifter.sv
module rtcseq_byte_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output logic             active,
    output logic [7:0]       rx_byte
);

    logic [DIV_W-1:0] tick;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sr;
    logic [7:0]       rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            done    <= 1'b0;
            tick    <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    tx_sr   <= tx_byte;
                    tick    <= '0;
                    bit_cnt <= '0;
                end
            end else if (tick == half_div) begin
                tick <= '0;
                if (!sclk) begin
                    // leading edge: present the next bit
                    sclk  <= 1'b1;
                    mosi  <= tx_sr[7];
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end else begin
                    // trailing edge: capture the returned bit
                    sclk    <= 1'b0;
                    rx_sr   <= {rx_sr[6:0], miso};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign rx_byte = rx_sr;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);  // R2
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);  // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R2

endmodule

// File: rtl/rtcseq_gap_timer.sv
module rtcseq_gap_timer #(
    parameter int GAP_CYC = 620,
    localparam int GAP_W  = $clog2(GAP_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    logic [GAP_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= GAP_W'(GAP_CYC);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);  // R9

endmodule

// File: rtl/rtc_spi_seq.sv
module rtc_spi_seq
    import rtcseq_pkg::*;
#(
    parameter int CLK_HZ    = 10_000_000,
    parameter int CS_GAP_US = 62,
    parameter int DIV_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    sclk_div,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [55:0]         req_time,
    output logic                req_ack,
    output logic [55:0]         rd_time,
    output logic                busy,
    output logic                probe_done,
    output logic                dev_absent,
    output logic                low_volt_warn,
    output logic                mode_24h,
    output logic                spi_cs,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso
);

    localparam int GAP_CYC = ((CLK_HZ / 1000) * CS_GAP_US + 999) / 1000;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    seq_state_t          state, state_n;
    job_t                job, follow;
    logic [IDX_W-1:0]    idx;
    logic [TIME_W-1:0]   wr_latch;
    logic [TIME_W-1:0]   rd_acc;
    logic [7:0]          tx_byte;
    logic [7:0]          rx_byte;
    logic                byte_start, byte_done, byte_active;
    logic                gap_load, gap_expired;
    logic                last_byte;

    assign last_byte  = (idx == job_len(job) - 1'b1);
    assign byte_start = (state == S_LAUNCH);
    assign gap_load   = (state == S_SHIFT) && byte_done && last_byte;
    assign busy       = (state != S_IDLE) && (state != S_ABSENT);

    rtcseq_tx_select u_tx_select (
        .job     (job),
        .idx     (idx),
        .wr_time (wr_latch),
        .tx_byte (tx_byte)
    );

    rtcseq_byte_shifter #(.DIV_W(DIV_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (sclk_div),
        .start    (byte_start),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .done     (byte_done),
        .active   (byte_active),
        .rx_byte  (rx_byte)
    );

    rtcseq_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            S_BOOT:   state_n = S_LAUNCH;
            S_IDLE:   if (req_valid) state_n = S_LAUNCH;
            S_LAUNCH: state_n = S_SHIFT;
            S_SHIFT: begin
                if (byte_done)
                    state_n = last_byte ? S_GAP : S_LAUNCH;
            end
            S_GAP: begin
                if (gap_expired) begin
                    if (follow != J_NONE) state_n = S_LAUNCH;
                    else if (dev_absent)  state_n = S_ABSENT;
                    else                  state_n = S_IDLE;
                end
            end
            S_ABSENT: state_n = S_ABSENT;
            default:  state_n = S_BOOT;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            job           <= J_PROBE_SEC;
            follow        <= J_NONE;
            idx           <= '0;
            wr_latch      <= '0;
            rd_acc        <= '0;
            rd_time       <= '0;
            req_ack       <= 1'b0;
            probe_done    <= 1'b0;
            dev_absent    <= 1'b0;
            low_volt_warn <= 1'b0;
            mode_24h      <= 1'b0;
            spi_cs        <= 1'b0;
        end else begin
            req_ack <= 1'b0;
            unique case (state)
                S_BOOT: begin
                    job <= J_PROBE_SEC;
                    idx <= '0;
                end
                S_IDLE: begin
                    if (req_valid) begin
                        job      <= req_write ? J_TIME_WR : J_TIME_RD;
                        wr_latch <= req_time;
                        idx      <= '0;
                        follow   <= J_NONE;
                    end
                end
                S_LAUNCH: spi_cs <= 1'b1;
                S_SHIFT: begin
                    if (byte_done) begin
                        if (job == J_TIME_RD && idx >= IDX_W'(PRE_BYTES))
                            rd_acc <= {rd_acc[TIME_W-9:0], rx_byte};
                        if (last_byte) begin
                            spi_cs <= 1'b0;
                            unique case (job)
                                J_PROBE_SEC: begin
                                    if (rx_byte[BIT_SEC_BAD]) begin
                                        dev_absent <= 1'b1;
                                        follow     <= J_NONE;
                                    end else begin
                                        follow     <= J_READ_CTL2;
                                    end
                                end
                                J_READ_CTL2: begin
                                    low_volt_warn <= rx_byte[BIT_LOW_VOLT];
                                    if (rx_byte[BIT_LOW_VOLT] || rx_byte[BIT_OSC_STOP])
                                        follow <= J_CLEAR_CTL2;
                                    else
                                        follow <= J_READ_CTL1;
                                end
                                J_CLEAR_CTL2: follow <= J_READ_CTL1;
                                J_READ_CTL1: begin
                                    mode_24h <= rx_byte[BIT_HOUR24];
                                    follow   <= J_NONE;
                                end
                                default: follow <= J_NONE;
                            endcase
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_expired) begin
                        if (follow != J_NONE) begin
                            job    <= follow;
                            idx    <= '0;
                            follow <= J_NONE;
                        end else begin
                            probe_done <= 1'b1;
                            if (job == J_TIME_RD || job == J_TIME_WR) begin
                                req_ack <= 1'b1;
                                if (job == J_TIME_RD) rd_time <= rd_acc;
                            end
                        end
                    end
                end
                S_ABSENT: spi_cs <= 1'b0;
                default: ;
            endcase
        end
    end

    // chip-select low-time observer for the gap property
    logic [GAP_W-1:0] cs_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cs_low_cnt <= GAP_W'(GAP_CYC);
        else if (spi_cs)                 cs_low_cnt <= '0;
        else if (cs_low_cnt != GAP_W'(GAP_CYC)) cs_low_cnt <= cs_low_cnt + 1'b1;
    end

    AST_CS_HELD_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT) |-> spi_cs);  // R8
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs) |-> (cs_low_cnt == GAP_W'(GAP_CYC)));  // R9
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);  // R10
    AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !busy);  // R10
    AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_absent && probe_done) |-> (!spi_cs && !req_ack));  // R3
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && $past(probe_done)) |-> $stable(mode_24h));  // R5
    AST_NO_ACK_BEFORE_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> probe_done);  // R11

endmodule

// File: tb/rtc_spi_seq_tb.sv
module rtc_spi_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ_TB  = 10_000_000;
    localparam int GAP_EXP    = CLK_HZ_TB / 1_000_000 * 62;
    localparam int WD_CYCLES  = 150_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sclk_div = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [55:0] req_time = '0;
    logic        req_ack;
    logic [55:0] rd_time;
    logic        busy, probe_done, dev_absent, low_volt_warn, mode_24h;
    logic        spi_cs, spi_sclk, spi_mosi;
    logic        spi_miso;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_spi_seq #(.CLK_HZ(CLK_HZ_TB), .CS_GAP_US(62), .DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_div(sclk_div),
        .req_valid(req_valid), .req_write(req_write), .req_time(req_time),
        .req_ack(req_ack), .rd_time(rd_time), .busy(busy),
        .probe_done(probe_done), .dev_absent(dev_absent),
        .low_volt_warn(low_volt_warn), .mode_24h(mode_24h),
        .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // ---------------- clock device model and link monitor ----------------
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [7:0] pre_data = '0;

    logic [7:0] regs [16];
    logic [7:0] hist [32][16];
    int         hist_len [32];
    int         win_count = 0;
    int         cur_len = 0;
    int         bits = 0;
    int         sl_mode = 0;
    logic [3:0] sl_addr = '0;
    logic       sl_rd = 1'b0;
    logic [7:0] sl_in = '0;
    logic [7:0] sl_out = '0;
    logic       prev_sclk = 1'b0;
    logic       prev_cs = 1'b0;
    int         high_run = 0;
    int         last_high = 0;
    int         low_run = 0;
    int         min_gap = 1_000_000;
    logic       seen_fall = 1'b0;

    initial spi_miso = 1'b0;

    always @(posedge clk) begin
        if (pre_we) regs[pre_addr] = pre_data;
        if (spi_sclk) high_run = high_run + 1;
        else if (high_run > 0) begin last_high = high_run; high_run = 0; end
        if (!spi_cs) low_run = low_run + 1;
        if (spi_cs && !prev_cs) begin
            if (seen_fall && low_run < min_gap) min_gap = low_run;
            low_run = 0;
            bits = 0; sl_mode = 0; cur_len = 0; sl_out = 8'h00;
        end else if (spi_cs) begin
            if (spi_sclk && !prev_sclk)
                spi_miso <= sl_out[7 - bits];
            if (!spi_sclk && prev_sclk) begin
                sl_in = {sl_in[6:0], spi_mosi};
                bits = bits + 1;
                if (bits == 8) begin
                    if (cur_len < 16) hist[win_count % 32][cur_len] = sl_in;
                    cur_len = cur_len + 1;
                    if (sl_mode == 0) begin
                        sl_addr = sl_in[7:4];
                        sl_rd   = sl_in[2];
                        sl_mode = sl_in[3] ? 1 : 2;
                    end else begin
                        if (!sl_rd) regs[sl_addr] = sl_in;
                        if (sl_mode == 1) sl_mode = 0;
                        else sl_addr = sl_addr + 4'd1;
                    end
                    bits = 0;
                    sl_out = (sl_mode != 0 && sl_rd) ? regs[sl_addr] : 8'h00;
                end
            end
        end
        if (!spi_cs && prev_cs) begin
            hist_len[win_count % 32] = cur_len;
            win_count = win_count + 1;
            seen_fall = 1'b1;
            low_run = 1;
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_win(input string req, input int w, input int len,
                             input logic [7:0] e [12]);
        bit ok;
        int bad;
        ok = (hist_len[w % 32] == len);
        bad = -1;
        for (int i = 0; i < len && i < 12; i++)
            if (ok && bad < 0 && hist[w % 32][i] !== e[i]) bad = i;
        if (!ok)
            chk(1'b0, req, "window length", 64'(hist_len[w % 32]), 64'(len));
        else if (bad >= 0)
            chk(1'b0, req, $sformatf("window %0d byte %0d", w, bad),
                64'(hist[w % 32][bad]), 64'(e[bad]));
        else
            chk(1'b1, req, "window", 0, 0);
    endtask

    task automatic preset(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic apply_reset(output int base);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!spi_cs && !spi_sclk, "R1", "cs/sclk in reset", {spi_cs, spi_sclk}, 0);
        chk(!req_ack && !probe_done && !dev_absent, "R1", "flags in reset",
            {req_ack, probe_done, dev_absent}, 0);
        base = win_count;
        rst_n = 1'b1;
    endtask

    task automatic wait_probe();
        int g = 0;
        while (!probe_done && g < 20000) begin @(negedge clk); g++; end
        chk(probe_done, "R5", "probe_done reached", probe_done, 1);
    endtask

    task automatic do_access(input logic wr, input logic [55:0] t,
                             output logic [55:0] got, output logic pd_at_ack);
        int g = 0;
        logic busy_mid;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_time = t;
        repeat (3) @(negedge clk);
        busy_mid = busy;
        while (!req_ack && g < 30000) begin @(negedge clk); g++; end
        chk(req_ack, "R10", "ack seen", req_ack, 1);
        chk(!busy, "R10", "busy low with ack", busy, 0);
        chk(busy_mid, "R11", "busy high during access", busy_mid, 1);
        got = rd_time;
        pd_at_ack = probe_done;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ack, "R10", "ack single cycle", req_ack, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_probe_flags_and_read();
        int base;
        logic [55:0] got;
        logic pd;
        logic [7:0] e [12];
        preset(4'd0, 8'h59); preset(4'd1, 8'h34); preset(4'd2, 8'h12);
        preset(4'd3, 8'h03); preset(4'd4, 8'h28); preset(4'd5, 8'h82);
        preset(4'd6, 8'h24); preset(4'd14, 8'h20); preset(4'd15, 8'h50);
        sclk_div = 8'd1;
        apply_reset(base);
        // request raised while the probe is still running
        do_access(1'b0, 56'h0, got, pd);
        chk(pd, "R11", "probe finished before ack", pd, 1);
        chk(win_count - base == 5, "R11", "probe windows precede access",
            64'(win_count - base), 5);
        e = '{8'h0C, 8'h00, 0,0,0,0,0,0,0,0,0,0};
        check_win("R3", base, 2, e);
        e = '{8'hFC, 8'h00, 0,0,0,0,0,0,0,0,0,0};
        check_win("R4", base + 1, 2, e);
        e = '{8'hF8, 8'h00, 0,0,0,0,0,0,0,0,0,0};
        check_win("R4", base + 2, 2, e);
        e = '{8'hEC, 8'h00, 0,0,0,0,0,0,0,0,0,0};
        check_win("R5", base + 3, 2, e);
        chk(regs[15] == 8'h00, "R4", "control cleared", regs[15], 0);
        chk(low_volt_warn, "R4", "low voltage warning", low_volt_warn, 1);
        chk(mode_24h, "R5", "24h mode", mode_24h, 1);
        chk(!dev_absent, "R3", "device present", dev_absent, 0);
        e = '{8'hFC, 8'h00, 8'hFC, 8'h00, 8'h04, 0,0,0,0,0,0,0};
        check_win("R6", base + 4, 12, e);
        check_win("R8", base + 4, 12, e);
        chk(got == 56'h59341203288224, "R6", "read time", got, 56'h59341203288224);
        chk(last_high == 2, "R2", "sclk phase div=1", 64'(last_high), 2);
    endtask

    task automatic t_write_then_read();
        int w0;
        logic [55:0] got;
        logic pd;
        logic [7:0] e [12];
        w0 = win_count;
        do_access(1'b1, 56'h07152306311299, got, pd);
        e = '{8'hFC, 8'h00, 8'hFC, 8'h00, 8'h00, 8'h07, 8'h15, 8'h23,
              8'h06, 8'h31, 8'h12, 8'h99};
        check_win("R7", w0, 12, e);
        chk({regs[0], regs[1], regs[2], regs[3], regs[4], regs[5], regs[6]}
            == 56'h07152306311299, "R7", "device registers",
            {regs[0], regs[1], regs[2], regs[3], regs[4], regs[5], regs[6]},
            56'h07152306311299);
        sclk_div = 8'd3;
        do_access(1'b0, 56'h0, got, pd);
        chk(got == 56'h07152306311299, "R6", "read back", got, 56'h07152306311299);
        chk(last_high == 4, "R2", "sclk phase div=3", 64'(last_high), 4);
        chk(min_gap >= GAP_EXP, "R9", "minimum cs gap", 64'(min_gap), 64'(GAP_EXP));
        sclk_div = 8'd1;
    endtask

    task automatic t_probe_clean();
        int base;
        logic [7:0] e [12];
        preset(4'd0, 8'h12); preset(4'd14, 8'h00); preset(4'd15, 8'h00);
        apply_reset(base);
        wait_probe();
        repeat (5) @(negedge clk);
        chk(win_count - base == 3, "R4", "no clear window", 64'(win_count - base), 3);
        e = '{8'hEC, 8'h00, 0,0,0,0,0,0,0,0,0,0};
        check_win("R5", base + 2, 2, e);
        chk(!mode_24h, "R5", "12h mode", mode_24h, 0);
        chk(!low_volt_warn, "R4", "no warning", low_volt_warn, 0);
    endtask

    task automatic t_probe_stop_only();
        int base;
        logic [7:0] e [12];
        preset(4'd14, 8'h20); preset(4'd15, 8'h10);
        apply_reset(base);
        wait_probe();
        chk(win_count - base == 4, "R4", "clear window present", 64'(win_count - base), 4);
        e = '{8'hF8, 8'h00, 0,0,0,0,0,0,0,0,0,0};
        check_win("R4", base + 2, 2, e);
        chk(!low_volt_warn, "R4", "stop flag gives no warning", low_volt_warn, 0);
        chk(regs[15] == 8'h00, "R4", "control cleared", regs[15], 0);
    endtask

    task automatic t_absent();
        int base;
        int after;
        bit acked;
        preset(4'd0, 8'h80);
        apply_reset(base);
        wait_probe();
        chk(dev_absent, "R3", "absent flagged", dev_absent, 1);
        chk(win_count - base == 1, "R3", "single probe window", 64'(win_count - base), 1);
        after = win_count;
        acked = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        repeat (3000) begin
            @(negedge clk);
            if (req_ack) acked = 1'b1;
        end
        req_valid = 1'b0;
        chk(!acked, "R3", "request ignored", acked, 0);
        chk(win_count == after, "R3", "no further windows", 64'(win_count), 64'(after));
        chk(!busy, "R3", "not busy", busy, 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_probe_flags_and_read();
        t_write_then_read();
        t_probe_clean();
        t_probe_stop_only();
        t_absent();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule